// File: doc/BRIEF.md
# Serial Divider Ratio Loader

This block receives divider ratios from a host over three wires: a shift clock, a data line and a load strobe. The host sends bits most significant first. The last bit it sends before raising the load strobe is a routing flag. When the load strobe rises, the routing flag decides where the captured word goes. A flag of 1 writes the 16-bit reference-divider ratio register. A flag of 0 writes the 24-bit feedback-divider ratio register.

The three host wires are asynchronous to the system clock. Each one passes through a two-stage synchronizer. Edges on the shift clock and the load strobe are then detected in the system clock domain. All shifting, decoding and register writes run on the system clock. Each write produces a one-cycle strobe for the register that changed. The divider counters that use these ratios sit outside this block.

Top module: `ser_ratio_loader`

## Requirements
- R1: While reset is asserted and after it is released, both ratio outputs read zero and both update strobes are low until the first load.
- R2: On each synchronized rising edge of `ser_clk` while the synchronized `ser_latch` is low, the bit on `ser_data` enters a 25-bit shift register at the least significant end. Data therefore arrives most significant bit first.
- R3: On a load whose routing flag (the last bit shifted, shift-register bit 0) is 1, `ref_ratio` takes the 16 bits shifted just before that flag (shift-register bits 16..1). `vco_ratio` is left unchanged. Any bits shifted earlier than those 17 have no effect.
- R4: On a load whose routing flag is 0, `vco_ratio` takes the 24 bits shifted just before that flag (shift-register bits 24..1). `ref_ratio` is left unchanged.
- R5: A load happens exactly once for each rising edge of `ser_latch`. Holding `ser_latch` high produces no further write and no further strobe.
- R6: Each load raises the strobe of the written register only (`ref_upd` for flag 1, `vco_upd` for flag 0), for exactly one system cycle. The two strobes are never high together.
- R7: Rising edges of `ser_clk` while `ser_latch` is high do not change the shift register.
- R8: When the synchronized rising edges of `ser_clk` and `ser_latch` fall in the same system cycle, no bit is shifted. The load uses the register contents as they were before that edge.
- R9: A load does not clear the shift register. A second `ser_latch` pulse with no new bits writes the same value to the same register again, with its strobe.
- R10: A rising edge of `ser_latch` that is set up before system clock edge k shows on the ratio output and its strobe just after edge k+2.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Host shift clock, asynchronous |
| ser_data | input | 1 | Host serial data, most significant bit first |
| ser_latch | input | 1 | Host load strobe, asynchronous; a rising edge commits the word |
| ref_ratio | output | 16 | Reference-divider ratio register |
| vco_ratio | output | 24 | Feedback-divider ratio register |
| ref_upd | output | 1 | One-cycle pulse when `ref_ratio` is written |
| vco_upd | output | 1 | One-cycle pulse when `vco_ratio` is written |

## Verification
A shift edge and a load edge can be detected in the same system cycle. This happens when the host raises `ser_clk` and `ser_latch` together. The bench provokes this by changing both wires in the same cycle, with a data value that would flip the routing flag if it were shifted. The result is judged by which register receives the word and by which strobe fires: the register and strobe from the earlier flag must win.

Shift clock edges during a long load-strobe high are exercised in the same way. They are followed by a reload that would expose any bit that slipped in. Reference and feedback loads are swept with walking-one and arithmetic patterns.

// File: rtl/ldr_pkg.sv
`timescale 1ns/1ps
package ldr_pkg;
    // routing flag carried in shift-register bit 0
    typedef enum logic {
        DEST_VCO = 1'b0,
        DEST_REF = 1'b1
    } dest_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/ldr_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer for one asynchronous host wire.
module ldr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level = s_q.chain[STAGES-1];
endmodule

// File: rtl/ldr_shifter.sv
`timescale 1ns/1ps
// Serial-in shift register; new bit enters at bit 0 (R2).
module ldr_shifter #(
    parameter int SR_W = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [SR_W-1:0] sr
);
    typedef struct packed {
        logic [SR_W-1:0] bits;
    } shreg_t;

    shreg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (shift_en) r_d.bits = {r_q.bits[SR_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sr = r_q.bits;
endmodule

// File: rtl/ldr_latch_bank.sv
`timescale 1ns/1ps
// Ratio registers plus their one-cycle write strobes (R3, R4, R6).
module ldr_latch_bank
    import ldr_pkg::*;
#(
    parameter int REF_W = 16,
    parameter int VCO_W = 24,
    parameter int SR_W  = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SR_W-1:0]  sr,
    output logic [REF_W-1:0] ref_ratio,
    output logic [VCO_W-1:0] vco_ratio,
    output logic             ref_upd,
    output logic             vco_upd
);
    typedef struct packed {
        logic [REF_W-1:0] ref_val;
        logic [VCO_W-1:0] vco_val;
        logic             ref_pulse;
        logic             vco_pulse;
    } bank_t;

    bank_t b_d, b_q;
    dest_e dest;

    assign dest = dest_e'(sr[0]);

    always_comb begin
        b_d           = b_q;
        b_d.ref_pulse = 1'b0;
        b_d.vco_pulse = 1'b0;
        if (load) begin
            if (dest == DEST_REF) begin
                b_d.ref_val   = sr[REF_W:1];
                b_d.ref_pulse = 1'b1;
            end else begin
                b_d.vco_val   = sr[VCO_W:1];
                b_d.vco_pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign ref_ratio = b_q.ref_val;
    assign vco_ratio = b_q.vco_val;
    assign ref_upd   = b_q.ref_pulse;
    assign vco_upd   = b_q.vco_pulse;
endmodule

// File: rtl/ser_ratio_loader.sv
`timescale 1ns/1ps
module ser_ratio_loader
    import ldr_pkg::*;
#(
    parameter int REF_W  = 16,
    parameter int VCO_W  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_latch,
    output logic [REF_W-1:0] ref_ratio,
    output logic [VCO_W-1:0] vco_ratio,
    output logic             ref_upd,
    output logic             vco_upd
);
    localparam int SR_W  = max_of(REF_W, VCO_W) + 1;
    localparam int N_IN  = 3;
    localparam int I_CLK = 0;
    localparam int I_DAT = 1;
    localparam int I_LE  = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] lvl;

    assign raw_in = {ser_latch, ser_data, ser_clk};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        ldr_sync #(.STAGES(STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[g]),
            .level (lvl[g])
        );
    end

    // edge-detect state for shift clock and load strobe
    typedef struct packed {
        logic clk_prev;
        logic le_prev;
    } edge_t;

    edge_t e_d, e_q;
    logic  clk_rise, le_rise, shift_en;
    logic [SR_W-1:0] sr;

    always_comb begin
        e_d          = e_q;
        e_d.clk_prev = lvl[I_CLK];
        e_d.le_prev  = lvl[I_LE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign clk_rise = lvl[I_CLK] & ~e_q.clk_prev;
    assign le_rise  = lvl[I_LE]  & ~e_q.le_prev;
    // R7/R8: no shifting while the synchronized load strobe is high
    assign shift_en = clk_rise & ~lvl[I_LE];

    ldr_shifter #(.SR_W(SR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (lvl[I_DAT]),
        .sr       (sr)
    );

    ldr_latch_bank #(.REF_W(REF_W), .VCO_W(VCO_W), .SR_W(SR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (le_rise),
        .sr        (sr),
        .ref_ratio (ref_ratio),
        .vco_ratio (vco_ratio),
        .ref_upd   (ref_upd),
        .vco_upd   (vco_upd)
    );
endmodule

// File: rtl/ldr_checker.sv
`timescale 1ns/1ps
module ldr_checker #(
    parameter int REF_W = 16,
    parameter int VCO_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_latch,
    input logic [REF_W-1:0] ref_ratio,
    input logic [VCO_W-1:0] vco_ratio,
    input logic             ref_upd,
    input logic             vco_upd
);
    assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_upd && vco_upd));

    assert_ref_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd |=> !ref_upd);

    assert_vco_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vco_upd |=> !vco_upd);

    assert_ref_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_ratio) |-> ref_upd);

    assert_vco_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vco_ratio) |-> vco_upd);

    assert_ref_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd |-> $past(ser_latch, 3));

    assert_vco_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vco_upd |-> $past(ser_latch, 3));
endmodule

bind ser_ratio_loader ldr_checker #(.REF_W(REF_W), .VCO_W(VCO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_latch (ser_latch),
    .ref_ratio (ref_ratio),
    .vco_ratio (vco_ratio),
    .ref_upd   (ref_upd),
    .vco_upd   (vco_upd)
);

// File: tb/tb_ser_ratio_loader.sv
`timescale 1ns/1ps
module tb_ser_ratio_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic        sle = 1'b0;
    logic [15:0] ref_ratio;
    logic [23:0] vco_ratio;
    logic        ref_upd, vco_upd;

    int n_tests = 0;
    int n_fail  = 0;
    int n_ref   = 0;
    int n_vco   = 0;
    bit done    = 1'b0;

    logic [24:0] m_sr  = '0;
    logic [15:0] e_ref = '0;
    logic [23:0] e_vco = '0;

    always #5 clk = ~clk;

    ser_ratio_loader dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (sclk),
        .ser_data  (sdata),
        .ser_latch (sle),
        .ref_ratio (ref_ratio),
        .vco_ratio (vco_ratio),
        .ref_upd   (ref_upd),
        .vco_upd   (vco_upd)
    );

    always @(negedge clk) begin
        if (ref_upd) n_ref++;
        if (vco_upd) n_vco++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        sdata = b;
        cyc(3);
        sclk = 1'b1;
        cyc(3);
        sclk = 1'b0;
        cyc(2);
        m_sr = {m_sr[23:0], b};
    endtask

    task automatic send_r(input logic [15:0] v);
        for (int i = 15; i >= 0; i--) send_bit(v[i]);
        send_bit(1'b1);
    endtask

    task automatic send_n(input logic [23:0] v);
        for (int i = 23; i >= 0; i--) send_bit(v[i]);
        send_bit(1'b0);
    endtask

    // load pulse; optional shift-clock toggles while the strobe is high
    task automatic load_check(input string req, input int toggles);
        bit to_ref;
        to_ref = m_sr[0];
        if (to_ref) e_ref = m_sr[16:1];
        else        e_vco = m_sr[24:1];
        cyc(1);
        #2;
        n_ref = 0;
        n_vco = 0;
        sle = 1'b1;
        cyc(6);
        repeat (toggles) begin
            sdata = ~to_ref;
            sclk  = 1'b1;
            cyc(3);
            sclk  = 1'b0;
            cyc(3);
        end
        sle = 1'b0;
        cyc(5);
        chk(ref_ratio == e_ref, req, "ref_ratio", ref_ratio, e_ref);
        chk(vco_ratio == e_vco, req, "vco_ratio", vco_ratio, e_vco);
        chk(n_ref == (to_ref ? 1 : 0), {req, " R6"}, "ref_upd count", n_ref, to_ref ? 1 : 0);
        chk(n_vco == (to_ref ? 0 : 1), {req, " R6"}, "vco_upd count", n_vco, to_ref ? 0 : 1);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(4);
        // R1: reset state
        chk(ref_ratio == 0 && vco_ratio == 0, "R1", "ratios in reset", {ref_ratio, vco_ratio}, 0);
        chk(!ref_upd && !vco_upd, "R1", "strobes in reset", {ref_upd, vco_upd}, 0);
        rst_n = 1'b1;
        cyc(6);
        chk(ref_ratio == 0 && vco_ratio == 0 && !ref_upd && !vco_upd, "R1", "after release",
            {ref_ratio, vco_ratio}, 0);

        // R2/R3: reference walking ones
        for (int i = 0; i < 16; i++) begin
            send_r(16'h1 << i);
            load_check("R2 R3 walk", 0);
        end
        // R2/R4: feedback walking ones
        for (int i = 0; i < 24; i++) begin
            send_n(24'h1 << i);
            load_check("R2 R4 walk", 0);
        end
        // R4: low-range packets, top byte zero, arithmetic low part
        for (int i = 0; i < 24; i++) begin
            send_n({8'h00, 16'(i * 16'h0B3D + 16'h0101)});
            load_check("R4 lowrange", 0);
        end
        // R3: reference packets with arithmetic values, preceded by junk bits
        for (int i = 0; i < 12; i++) begin
            send_bit(1'b1);
            send_bit(1'b0);
            send_bit(1'b1);
            send_r(16'(i * 16'h2F1B + 16'h8001));
            load_check("R3 junk", 0);
        end

        // R7 + R5: shift edges while load is held high; then R9 reload
        send_r(16'h1234);
        load_check("R7 R5 held", 4);
        load_check("R9 R7 reload", 0);
        send_n(24'hA5C3F0);
        load_check("R7 R5 held n", 3);
        load_check("R9 reload n", 0);

        // R8: shift and load edges in the same cycle
        send_r(16'hBEEF);
        e_ref = 16'hBEEF;
        cyc(1);
        #2;
        n_ref = 0;
        n_vco = 0;
        @(negedge clk);
        sdata = 1'b0;
        sclk  = 1'b1;
        sle   = 1'b1;
        cyc(8);
        sclk  = 1'b0;
        sle   = 1'b0;
        cyc(5);
        chk(ref_ratio == 16'hBEEF, "R8", "ref_ratio", ref_ratio, 16'hBEEF);
        chk(vco_ratio == e_vco, "R8", "vco_ratio", vco_ratio, e_vco);
        chk(n_ref == 1 && n_vco == 0, "R8", "strobe counts", {n_ref[7:0], n_vco[7:0]}, 16'h0100);
        load_check("R8 R9 no bit slipped", 0);

        // R10: latency of load to outputs
        send_n(24'h00C0DE);
        @(negedge clk);
        sle = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk(vco_ratio == e_vco && !vco_upd, "R10", "before edge k+2", vco_ratio, e_vco);
        @(posedge clk);
        #1;
        chk(vco_ratio == 24'h00C0DE, "R10", "vco_ratio at edge k+2", vco_ratio, 24'h00C0DE);
        chk(vco_upd == 1'b1, "R10", "vco_upd at edge k+2", vco_upd, 1);
        @(posedge clk);
        #1;
        chk(vco_upd == 1'b0, "R6", "vco_upd one cycle", vco_upd, 0);
        e_vco = 24'h00C0DE;
        cyc(4);
        sle = 1'b0;
        cyc(5);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule